// File: doc/BRIEF.md
# Boot-Time Serial EEPROM Configuration Loader

After reset this block acts as the only master on a two-wire I2C bus. It fetches a fixed window of configuration bytes from an external serial EEPROM. Each byte goes into a register file through a plain write port made of an address, a data byte and a one-cycle strobe. The block drives SCL and SDA as open-drain lines. Each line has an output-enable pin, where 1 pulls the line low, and an input pin that reads the wired level.

A board that carries an EEPROM fits a pull-up on SCL. In the first clock after `rst_ni` is released, the block reads SCL. If SCL is high, the block performs one sequential read of `NUM_BYTES` bytes (96 by default) that starts at `BASE_OFFSET` (00h by default). If SCL is low, the block goes straight to done and makes no bus activity. When the load ends, `done_o` is set. `err_o` reports an aborted transfer.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: SCL and SDA are never driven high. The block only asserts `scl_oe_o`/`sda_oe_o` (1 = pull low) or releases them. Both are released while in reset.
- R2: In the first clock after reset release, if `scl_i` is low, the block sets `done_o=1` and `err_o=0`, pulls neither line, and issues no register writes.
- R3: If `scl_i` is high at that point, the bus sequence is as follows. START. Device-select byte for write, which is 1010, then `BASE_OFFSET[10:8]`, then bit0=0 (A0h by default). Word-address byte `BASE_OFFSET[7:0]`. Repeated START. Device-select byte for read, with bit0=1 (A1h by default). All bytes are sent MSB first.
- R4: Each received data byte produces exactly one one-cycle `wr_en_o` pulse. `wr_addr_o` counts 0, 1, … `NUM_BYTES-1` in order, and `wr_data_o` equals the byte read from EEPROM offset `BASE_OFFSET + wr_addr_o`.
- R5: The master ACKs (SDA low in the ninth bit) every data byte except the last. It NACKs the last byte (SDA released) and then issues STOP.
- R6: If the EEPROM NACKs the write device-select byte, the word-address byte or the read device-select byte, the load aborts. `err_o` becomes 1, STOP is issued, `done_o` becomes 1, and no further register writes occur.
- R7: SDA changes only while SCL is low, except for the SDA edges that form START and STOP while SCL is high. A full load shows exactly two START conditions and one STOP.
- R8: Every SCL high pulse lasts exactly 2×`QTR_CYC` clock cycles. A bit period is 4×`QTR_CYC` cycles.
- R9: `done_o` and `err_o` stay set until the next reset. While `done_o` is high, both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Wired level of SCL; also read as the presence strap |
| sda_i | input | 1 | Wired level of SDA |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en_o | output | 1 | One-cycle register-file write strobe |
| wr_addr_o | output | ADDR_W | Register-file byte offset |
| wr_data_o | output | 8 | Register-file write data |
| done_o | output | 1 | Load finished, or skipped when no EEPROM is present |
| err_o | output | 1 | Load aborted on a missing acknowledge |

## Verification
The bench builds the loader with `QTR_CYC=3`, which gives a 12-cycle bit. A full 96-byte load, including the final NACK and STOP, therefore finishes in roughly ten thousand cycles. This makes it practical to run the complete window several times, once per strap and NACK scenario. `NUM_BYTES` and `BASE_OFFSET` keep their defaults, so the device-select and word-address bytes are A0h/A1h and 00h. The behavioural EEPROM in the bench can refuse any one of the three addressing bytes, which brings each abort path of R6 within reach.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WRITE, OP_READ} i2c_op_e;

  typedef enum logic [3:0] {
    S_STRAP, S_START, S_DEVW, S_WADDR, S_RSTART, S_DEVR, S_READ, S_STOP, S_DONE
  } ldr_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int unsigned EE_ADDR_W = 11;
endpackage

// File: rtl/cfg_ldr_tick.sv
module cfg_ldr_tick #(
  parameter int unsigned QTR_CYC = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QTR_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || cnt_q == LAST) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/cfg_ldr_bit_eng.sv
module cfg_ldr_bit_eng
  import cfg_ldr_pkg::*;
#(
  parameter int unsigned QTR_CYC = 63
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  i2c_op_e    cmd_op_i,
  input  logic [7:0] tx_byte_i,
  input  logic       mst_nack_i,
  input  logic       sda_i,
  output logic       ready_o,
  output logic       done_o,
  output logic [7:0] rx_byte_o,
  output logic       slv_nack_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic       busy_q, done_q, mnack_q, ack_q;
  i2c_op_e    op_q;
  logic [1:0] phase_q;
  logic [3:0] bitc_q;
  logic [7:0] sh_q;
  logic       scl_oe_q, sda_oe_q;
  logic       scl_low_c, sda_low_c;
  logic       tick, accept;

  assign accept = !busy_q && cmd_valid_i;

  cfg_ldr_tick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .tick_o(tick)
  );

  // quarter-phase waveform per operation
  always_comb begin
    scl_low_c = 1'b0;
    sda_low_c = 1'b0;
    unique case (op_q)
      OP_START: begin
        scl_low_c = (phase_q == 2'd0) || (phase_q == 2'd3);
        sda_low_c = phase_q[1];
      end
      OP_STOP: begin
        scl_low_c = (phase_q == 2'd0);
        sda_low_c = !phase_q[1];
      end
      OP_WRITE: begin
        scl_low_c = (phase_q == 2'd0) || (phase_q == 2'd3);
        sda_low_c = (bitc_q < 4'd8) ? !sh_q[7] : 1'b0;
      end
      default: begin
        scl_low_c = (phase_q == 2'd0) || (phase_q == 2'd3);
        sda_low_c = (bitc_q == 4'd8) ? !mnack_q : 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      mnack_q  <= 1'b0;
      ack_q    <= 1'b0;
      op_q     <= OP_STOP;
      phase_q  <= '0;
      bitc_q   <= '0;
      sh_q     <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        scl_oe_q <= scl_low_c;
        sda_oe_q <= sda_low_c;
      end
      if (accept) begin
        busy_q  <= 1'b1;
        op_q    <= cmd_op_i;
        phase_q <= '0;
        bitc_q  <= '0;
        mnack_q <= mst_nack_i;
        if (cmd_op_i == OP_WRITE) sh_q <= tx_byte_i;
      end else if (busy_q && tick) begin
        if (phase_q == 2'd2) begin
          if (op_q == OP_READ && bitc_q < 4'd8)   sh_q  <= {sh_q[6:0], sda_i};
          if (op_q == OP_WRITE && bitc_q == 4'd8) ack_q <= sda_i;
        end
        phase_q <= phase_q + 2'd1;
        if (phase_q == 2'd3) begin
          if (op_q == OP_START || op_q == OP_STOP || bitc_q == 4'd8) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bitc_q <= bitc_q + 4'd1;
            if (op_q == OP_WRITE) sh_q <= {sh_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign ready_o    = !busy_q;
  assign done_o     = done_q;
  assign rx_byte_o  = sh_q;
  assign slv_nack_o = ack_q;
  assign scl_oe_o   = scl_oe_q;
  assign sda_oe_o   = sda_oe_q;

  // R7: outside START/STOP, SDA moves only with SCL held low
  a_r7_sda_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_q) && !$past(busy_q && (op_q == OP_START || op_q == OP_STOP)))
      |-> (scl_oe_q && $past(scl_oe_q)));

  a_r3_cmd_only_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
endmodule

// File: rtl/cfg_ldr_seq.sv
module cfg_ldr_seq
  import cfg_ldr_pkg::*;
#(
  parameter int unsigned NUM_BYTES   = 96,
  parameter int unsigned BASE_OFFSET = 0,
  parameter int unsigned ADDR_W      = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              eng_ready_i,
  input  logic              eng_done_i,
  input  logic [7:0]        eng_rx_i,
  input  logic              eng_nack_i,
  output logic              cmd_valid_o,
  output i2c_op_e           cmd_op_o,
  output logic [7:0]        tx_byte_o,
  output logic              mst_nack_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [EE_ADDR_W-1:0] BASE  = EE_ADDR_W'(BASE_OFFSET);
  localparam logic [2:0]           PAGE  = BASE[10:8];
  localparam logic [7:0]           WORD  = BASE[7:0];
  localparam logic [ADDR_W-1:0]    LAST  = ADDR_W'(NUM_BYTES - 1);

  ldr_state_e        state_q;
  logic              issued_q, done_q, err_q, wr_en_q;
  logic [ADDR_W-1:0] cnt_q, wr_addr_q;
  logic [7:0]        wr_data_q;
  logic              active;

  assign active = (state_q != S_STRAP) && (state_q != S_DONE);

  always_comb begin
    cmd_op_o  = OP_WRITE;
    tx_byte_o = 8'h00;
    unique case (state_q)
      S_START, S_RSTART: cmd_op_o = OP_START;
      S_DEVW:  tx_byte_o = {DEV_TYPE, PAGE, 1'b0};
      S_WADDR: tx_byte_o = WORD;
      S_DEVR:  tx_byte_o = {DEV_TYPE, PAGE, 1'b1};
      S_READ:  cmd_op_o  = OP_READ;
      S_STOP:  cmd_op_o  = OP_STOP;
      default: ;
    endcase
  end

  assign cmd_valid_o = active && !issued_q && eng_ready_i;
  assign mst_nack_o  = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_STRAP;
      issued_q  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      cnt_q     <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (state_q == S_STRAP) begin
        if (scl_i) state_q <= S_START;
        else begin
          state_q <= S_DONE;
          done_q  <= 1'b1;
        end
      end else if (cmd_valid_o) begin
        issued_q <= 1'b1;
      end else if (issued_q && eng_done_i) begin
        issued_q <= 1'b0;
        unique case (state_q)
          S_START:  state_q <= S_DEVW;
          S_RSTART: state_q <= S_DEVR;
          S_DEVW, S_WADDR, S_DEVR: begin
            if (eng_nack_i) begin
              err_q   <= 1'b1;
              state_q <= S_STOP;
            end else begin
              state_q <= (state_q == S_DEVW) ? S_WADDR :
                         (state_q == S_WADDR) ? S_RSTART : S_READ;
            end
          end
          S_READ: begin
            wr_en_q   <= 1'b1;
            wr_addr_q <= cnt_q;
            wr_data_q <= eng_rx_i;
            if (cnt_q == LAST) state_q <= S_STOP;
            else               cnt_q   <= cnt_q + 1'b1;
          end
          S_STOP: begin
            state_q <= S_DONE;
            done_q  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

  a_r4_wr_addr_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> (wr_addr_q <= LAST));
  a_r4_wr_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |=> !wr_en_q);
  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r6_no_write_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_q) |-> !wr_en_q);
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import cfg_ldr_pkg::*;
#(
  parameter int unsigned QTR_CYC     = 63,
  parameter int unsigned NUM_BYTES   = 96,
  parameter int unsigned BASE_OFFSET = 0,
  localparam int unsigned ADDR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              done_o,
  output logic              err_o
);
  logic       cmd_valid, eng_ready, eng_done, eng_nack, mst_nack;
  i2c_op_e    cmd_op;
  logic [7:0] tx_byte, rx_byte;

  cfg_ldr_seq #(
    .NUM_BYTES  (NUM_BYTES),
    .BASE_OFFSET(BASE_OFFSET),
    .ADDR_W     (ADDR_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .eng_ready_i(eng_ready),
    .eng_done_i (eng_done),
    .eng_rx_i   (rx_byte),
    .eng_nack_i (eng_nack),
    .cmd_valid_o(cmd_valid),
    .cmd_op_o   (cmd_op),
    .tx_byte_o  (tx_byte),
    .mst_nack_o (mst_nack),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  cfg_ldr_bit_eng #(.QTR_CYC(QTR_CYC)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid),
    .cmd_op_i   (cmd_op),
    .tx_byte_i  (tx_byte),
    .mst_nack_i (mst_nack),
    .sda_i      (sda_i),
    .ready_o    (eng_ready),
    .done_o     (eng_done),
    .rx_byte_o  (rx_byte),
    .slv_nack_o (eng_nack),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o)
  );

  a_r9_bus_free_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!scl_oe_o && !sda_oe_o));
  a_r1_no_write_while_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !done_o);
endmodule

// File: tb/eeprom_cfg_loader_bench.sv
module eeprom_cfg_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 3;
  localparam int NB         = 96;
  localparam int AW         = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_low = 1'b0;
  logic slv_low = 1'b0;
  logic scl_oe, sda_oe, wr_en, done, err;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  wire scl = !(scl_oe || strap_low);
  wire sda = !(sda_oe || slv_low);

  always #(CLK_PERIOD/2) clk = !clk;

  eeprom_cfg_loader #(.QTR_CYC(QTR), .NUM_BYTES(NB), .BASE_OFFSET(0)) u_eeprom_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .done_o(done), .err_o(err));

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [10:0] a);
    return 8'(32'(a) * 37 + 11) ^ 8'hA5;
  endfunction

  // ---------------- EEPROM model ----------------
  int inject = 0; // 1: nack devsel-W, 2: nack word addr, 3: nack devsel-R
  int starts, stops, acks, nacks, last_ack_idx, rd_bytes;
  logic [7:0] dev_w, dev_r, waddr;
  bit s_act, s_first, s_rx, s_rd;
  int s_bit, s_byte;
  logic [7:0] s_sh, s_tx;
  logic [10:0] s_ptr;
  logic s_mack;

  always @(negedge sda) if (scl === 1'b1 && rst_n) begin
    starts++; s_act = 1; s_first = 1; s_rx = 1; s_bit = 0; s_byte = 0; slv_low = 0;
  end
  always @(posedge sda) if (scl === 1'b1 && rst_n) begin
    stops++; s_act = 0; slv_low = 0;
  end
  always @(posedge scl) if (s_act && !s_first) begin
    if (s_bit < 8) begin
      if (s_rx) s_sh = {s_sh[6:0], sda};
    end else if (!s_rx) s_mack = sda;
  end
  always @(negedge scl) if (s_act) begin
    if (s_first) s_first = 0;
    else if (s_bit < 7) begin
      s_bit++;
      if (!s_rx) slv_low = !s_tx[7-s_bit];
    end else if (s_bit == 7) begin
      s_bit = 8;
      if (s_rx) begin
        slv_low = 1;
        if (s_byte == 0) begin
          s_rd = s_sh[0];
          if (s_rd) dev_r = s_sh; else dev_w = s_sh;
          if (s_sh[7:4] != 4'hA || (inject == 1 && !s_rd) || (inject == 3 && s_rd)) slv_low = 0;
        end else if (s_byte == 1 && !s_rd) begin
          waddr = s_sh;
          s_ptr = {dev_w[3:1], s_sh};
          if (inject == 2) slv_low = 0;
        end
      end else slv_low = 0;
    end else begin
      s_bit = 0;
      s_byte++;
      if (s_rx) begin
        slv_low = 0;
        if (s_rd && s_byte == 1) begin
          s_rx = 0; s_tx = mem_byte(s_ptr); slv_low = !s_tx[7];
        end
      end else begin
        if (!s_mack) begin
          acks++; last_ack_idx = rd_bytes; rd_bytes++;
          s_ptr++; s_tx = mem_byte(s_ptr); slv_low = !s_tx[7];
        end else begin
          nacks++; rd_bytes++; slv_low = 0; s_act = 0;
        end
      end
    end
  end

  // ---------------- SCL high-pulse monitor (R8) ----------------
  int hi_run, falls, bad_hi, bad_len;
  always @(posedge clk) begin
    if (scl) hi_run++;
    else begin
      if (hi_run > 0) begin
        if (falls > 0 && hi_run != 2*QTR) begin bad_hi++; bad_len = hi_run; end
        falls++;
      end
      hi_run = 0;
    end
  end

  // ---------------- scoreboard ----------------
  logic [14:0] exp_q[$];
  int n_wr;

  task automatic push_expected(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back({8'(i), mem_byte(11'(i))});
  endtask

  always @(negedge clk) if (rst_n && wr_en) begin
    n_wr++;
    if (exp_q.size() == 0) chk(0, "R4 unexpected write", int'(wr_addr), -1);
    else begin
      logic [14:0] e;
      e = exp_q.pop_front();
      chk(wr_addr == e[14:8], "R4 write address", int'(wr_addr), int'(e[14:8]));
      chk(wr_data == e[7:0],  "R4 write data",    int'(wr_data), int'(e[7:0]));
    end
  end

  // ---------------- helpers ----------------
  task automatic do_reset(input bit no_eeprom, input int inj);
    rst_n = 0; inject = inj; strap_low = no_eeprom;
    repeat (3) @(posedge clk);
    starts = 0; stops = 0; acks = 0; nacks = 0; rd_bytes = 0; last_ack_idx = -1;
    dev_w = 0; dev_r = 0; waddr = 8'hFF; s_act = 0; slv_low = 0;
    n_wr = 0; hi_run = 0; falls = 0; bad_hi = 0; bad_len = 0;
    exp_q.delete();
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 lines released in reset", int'({scl_oe, sda_oe}), 0);
    chk(!done && !err && !wr_en, "R9 outputs clear in reset", int'({done, err, wr_en}), 0);
    rst_n = 1;
    repeat (4) @(posedge clk);
    strap_low = 0;
  endtask

  task automatic wait_done(input int limit);
    int c = 0;
    while (!done && c < limit) begin @(negedge clk); c++; end
    chk(done, "R9 done reached before watchdog", int'(done), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // Full load
    do_reset(0, 0);
    push_expected(NB);
    wait_done(20000);
    repeat (50) @(negedge clk);
    chk(!err, "R4 load without error", int'(err), 0);
    chk(exp_q.size() == 0, "R4 all bytes written", exp_q.size(), 0);
    chk(n_wr == NB, "R4 write count", n_wr, NB);
    chk(dev_w == 8'hA0, "R3 write device select", int'(dev_w), 8'hA0);
    chk(waddr == 8'h00, "R3 word address", int'(waddr), 0);
    chk(dev_r == 8'hA1, "R3 read device select", int'(dev_r), 8'hA1);
    chk(acks == NB-1, "R5 master acks", acks, NB-1);
    chk(nacks == 1 && last_ack_idx == NB-2, "R5 last byte nacked", nacks, 1);
    chk(starts == 2, "R7 start count", starts, 2);
    chk(stops == 1, "R5 stop after last byte", stops, 1);
    chk(bad_hi == 0 && falls > 100, "R8 scl high pulse width", bad_len, 2*QTR);
    chk(!scl_oe && !sda_oe, "R9 bus released when done", int'({scl_oe, sda_oe}), 0);
    chk(done, "R9 done sticky", int'(done), 1);

    // No EEPROM strap
    do_reset(1, 0);
    repeat (200) @(negedge clk);
    chk(done && !err, "R2 done without error", int'({done, err}), 2);
    chk(n_wr == 0, "R2 no writes", n_wr, 0);
    chk(starts == 0 && !scl_oe && !sda_oe, "R2 no bus activity", starts, 0);

    // NACK on each addressing byte
    for (int k = 1; k <= 3; k++) begin
      do_reset(0, k);
      wait_done(20000);
      repeat (50) @(negedge clk);
      chk(err, "R6 error flag on nack", int'(err), 1);
      chk(n_wr == 0, "R6 no writes after nack", n_wr, 0);
      chk(stops == 1, "R6 stop issued", stops, 1);
      chk(starts == ((k == 3) ? 2 : 1), "R7 start count on abort", starts, (k == 3) ? 2 : 1);
      chk(!scl_oe && !sda_oe, "R1 lines released after abort", int'({scl_oe, sda_oe}), 0);
      repeat (100) @(negedge clk);
      chk(done && err, "R9 flags sticky", int'({done, err}), 3);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule